// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock domains of a small processor keep running when the processor executes its idle instruction, and it brings them back in a safe order when a wake condition arrives. A two-bit mode input, driven from a control register outside the block, picks one of three sleep depths. The light depth stops only the CPU clock. The middle depth also stops the system clock. The deepest depth (halt) switches off every clock, the PLL and the oscillator.

Each depth has its own set of wake sources. The light depth wakes on any peripheral interrupt that is enabled both locally and globally, on an external pin, or on a reset request. The middle depth wakes on a wakeup-capable peripheral request, on an external pin, or on a reset request. An external pin in the middle depth restarts the stopped clocks through unclocked logic, and a registered copy of the pin is then forwarded as an interrupt request. Halt is left only through a reset request. That path restarts the oscillator, waits for a stable oscillator for a programmable number of reference cycles, restores the PLL and the watchdog clock, then restores the system and CPU clocks and pulses the start of the CPU reset sequence.

An idle strobe that arrives while a wake condition for the selected depth is already present is dropped, and the processor keeps running. A status output reports the sequencer state.

Top module: `lpm_sequencer`

## Requirements
- R1: In the run state, an idle strobe with mode 00 enters light idle, mode 01 enters middle idle, and mode 10 or 11 enters halt, effective after the clock edge that samples the strobe. The status output reads 0 for run, 1 for light idle, 2 for middle idle, 3 for halt and 4 for waking.
- R2: In light idle the CPU clock enable is 0, while the system clock, watchdog clock, PLL and oscillator enables are 1.
- R3: In middle idle the CPU and system clock enables are 0, while the watchdog clock, PLL and oscillator enables are 1.
- R4: In halt all five enables are 0.
- R5: Light idle returns to run on a peripheral interrupt bit whose local enable and the global enable are both 1, on any external pin, or on the reset request. A peripheral interrupt that lacks either enable leaves the block in light idle.
- R6: Middle idle returns to run on any wakeup request, any external pin, or the reset request. An enabled peripheral interrupt leaves the block in middle idle.
- R7: In middle idle, a high external pin raises the CPU and system clock enables in the same cycle, before any clock edge.
- R8: Halt ignores peripheral interrupts, external pins and wakeup requests. A reset request moves it to waking, with only the oscillator enable at 1.
- R9: While waking, the oscillator-ready input must be high on SETTLE_CYC consecutive edges, and a low edge restarts the count. The block then holds the PLL, watchdog and oscillator enables at 1 with the system and CPU enables at 0 for one cycle, and then returns to run.
- R10: The reset-sequence start output is a one-cycle pulse in the first run cycle after a halt exit, and stays 0 after an exit from light or middle idle.
- R11: An idle strobe that arrives while a wake source for the selected depth is already present leaves the block in run with all enables at 1.
- R12: Each external interrupt request output repeats its pin one clock edge later, in every state.
- R13: While rst_n is low, the status is run, all enables are 1, and the start pulse and the interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| lpm_mode | input | 2 | Sleep depth select (00 light, 01 middle, 1x halt) |
| idle_strobe | input | 1 | One-cycle pulse when the idle instruction executes |
| per_irq | input | NPER | Peripheral interrupt flags |
| per_ie | input | NPER | Local enables of the peripheral interrupts |
| glb_ie | input | 1 | Global interrupt enable |
| ext_pin | input | NEXT | External interrupt pins |
| wkup_req | input | NWK | Wakeup-capable peripheral requests |
| rst_req | input | 1 | Reset request from any source |
| osc_ready | input | 1 | Oscillator stable indication |
| clk_cpu_en | output | 1 | CPU clock domain enable |
| clk_sys_en | output | 1 | System clock domain enable |
| clk_wd_en | output | 1 | Watchdog clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| ext_irq_req | output | NEXT | Registered external interrupt requests |
| reset_seq_start | output | 1 | Pulse that starts the CPU reset sequence |
| lpm_status | output | 3 | Current state code |

## Verification
The bench builds the sequencer with three peripheral interrupts, two external pins, two wakeup requests and SETTLE_CYC set to 8. The short settle window lets the bench count every waking cycle exactly: it checks the edge on which the PLL returns, the single cycle before the system clock returns, and a restart of the count after a one-edge dropout of the oscillator-ready input. Several interrupt and pin lines let the bench separate a local enable from the global enable, and a pin from a wakeup request.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

   typedef enum logic [2:0] {
      S_RUN      = 3'd0,
      S_IDLE_L   = 3'd1,
      S_IDLE_M   = 3'd2,
      S_HALT     = 3'd3,
      S_WAKE_OSC = 3'd4,
      S_WAKE_PLL = 3'd5
   } lpm_state_e;

   typedef enum logic [1:0] {
      LVL_LIGHT = 2'd0,
      LVL_MID   = 2'd1,
      LVL_HALT  = 2'd2
   } lpm_level_e;

   localparam logic [2:0] STAT_WAKING = 3'd4;

   typedef struct packed {
      logic cpu;
      logic sys;
      logic wd;
      logic pll;
      logic osc;
   } clk_en_t;

   function automatic lpm_level_e level_of(input logic [1:0] mode);
      if (mode[1])      return LVL_HALT;
      else if (mode[0]) return LVL_MID;
      else              return LVL_LIGHT;
   endfunction

   function automatic clk_en_t en_for(input lpm_state_e s);
      clk_en_t e;
      unique case (s)
         S_RUN:      e = '{cpu: 1'b1, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
         S_IDLE_L:   e = '{cpu: 1'b0, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
         S_IDLE_M:   e = '{cpu: 1'b0, sys: 1'b0, wd: 1'b1, pll: 1'b1, osc: 1'b1};
         S_HALT:     e = '{cpu: 1'b0, sys: 1'b0, wd: 1'b0, pll: 1'b0, osc: 1'b0};
         S_WAKE_OSC: e = '{cpu: 1'b0, sys: 1'b0, wd: 1'b0, pll: 1'b0, osc: 1'b1};
         S_WAKE_PLL: e = '{cpu: 1'b0, sys: 1'b0, wd: 1'b1, pll: 1'b1, osc: 1'b1};
         default:    e = '{cpu: 1'b1, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
`timescale 1ns/1ps
// Combinational qualification of wake sources for each sleep depth.
module lpm_wake_qual #(
   parameter int NPER = 4,
   parameter int NEXT = 2,
   parameter int NWK  = 1
) (
   input  logic [NPER-1:0] per_irq,
   input  logic [NPER-1:0] per_ie,
   input  logic            glb_ie,
   input  logic [NEXT-1:0] ext_pin,
   input  logic [NWK-1:0]  wkup_req,
   input  logic            rst_req,
   output logic            ext_any,
   output logic            wake_light,
   output logic            wake_mid,
   output logic            wake_halt
);
   logic per_hit;

   always_comb begin
      per_hit    = glb_ie & (|(per_irq & per_ie));
      ext_any    = |ext_pin;
      wake_light = per_hit | ext_any | rst_req;
      wake_mid   = (|wkup_req) | ext_any | rst_req;
      wake_halt  = rst_req;
   end
endmodule

// File: rtl/lpm_settle_timer.sv
`timescale 1ns/1ps
// Counts consecutive oscillator-ready edges while the sequencer is waking.
module lpm_settle_timer #(
   parameter int SETTLE_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ready,
   output logic done
);
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   if (SETTLE_CYC == 1) begin : g_direct
      assign done = active & ready;
   end else begin : g_count
      localparam int CW = $clog2(SETTLE_CYC);
      localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt <= '0;
         else if (!active || !ready) cnt <= '0;
         else if (cnt != LAST)      cnt <= cnt + 1'b1;
      end

      assign done = active & ready & (cnt == LAST);

      // R9: completion needs ready on the preceding edge as well
      assert_settle_consec_R9: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> $past(ready));
   end
endmodule

// File: rtl/lpm_irq_fwd.sv
`timescale 1ns/1ps
// Clocked path that turns each external pin into a request for the interrupt controller.
module lpm_irq_fwd #(
   parameter int NEXT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEXT-1:0] ext_pin,
   output logic [NEXT-1:0] ext_irq_req
);
   for (genvar i = 0; i < NEXT; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_irq_req[i] <= 1'b0;
         else        ext_irq_req[i] <= ext_pin[i];
      end
   end
endmodule

// File: rtl/lpm_sequencer.sv
`timescale 1ns/1ps
module lpm_sequencer
   import lpm_pkg::*;
#(
   parameter int NPER       = 4,
   parameter int NEXT       = 2,
   parameter int NWK        = 1,
   parameter int SETTLE_CYC = 1024
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      lpm_mode,
   input  logic            idle_strobe,
   input  logic [NPER-1:0] per_irq,
   input  logic [NPER-1:0] per_ie,
   input  logic            glb_ie,
   input  logic [NEXT-1:0] ext_pin,
   input  logic [NWK-1:0]  wkup_req,
   input  logic            rst_req,
   input  logic            osc_ready,
   output logic            clk_cpu_en,
   output logic            clk_sys_en,
   output logic            clk_wd_en,
   output logic            pll_en,
   output logic            osc_en,
   output logic [NEXT-1:0] ext_irq_req,
   output logic            reset_seq_start,
   output logic [2:0]      lpm_status
);
   if (NPER < 1 || NEXT < 1 || NWK < 1) begin : g_bad_width
      $error("NPER, NEXT and NWK must each be at least 1");
   end

   lpm_state_e state, state_nx;
   lpm_level_e lvl;
   logic       ext_any, wake_light, wake_mid, wake_halt;
   logic       pending_sel, settle_done;
   clk_en_t    en;

   lpm_wake_qual #(.NPER(NPER), .NEXT(NEXT), .NWK(NWK)) u_qual (
      .per_irq    (per_irq),
      .per_ie     (per_ie),
      .glb_ie     (glb_ie),
      .ext_pin    (ext_pin),
      .wkup_req   (wkup_req),
      .rst_req    (rst_req),
      .ext_any    (ext_any),
      .wake_light (wake_light),
      .wake_mid   (wake_mid),
      .wake_halt  (wake_halt)
   );

   lpm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state == S_WAKE_OSC),
      .ready  (osc_ready),
      .done   (settle_done)
   );

   lpm_irq_fwd #(.NEXT(NEXT)) u_fwd (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_pin     (ext_pin),
      .ext_irq_req (ext_irq_req)
   );

   always_comb begin
      lvl = level_of(lpm_mode);
      unique case (lvl)
         LVL_LIGHT: pending_sel = wake_light;
         LVL_MID:   pending_sel = wake_mid;
         default:   pending_sel = wake_halt;
      endcase
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         S_RUN: if (idle_strobe && !pending_sel) begin
            unique case (lvl)
               LVL_LIGHT: state_nx = S_IDLE_L;
               LVL_MID:   state_nx = S_IDLE_M;
               default:   state_nx = S_HALT;
            endcase
         end
         S_IDLE_L:   if (wake_light)  state_nx = S_RUN;
         S_IDLE_M:   if (wake_mid)    state_nx = S_RUN;
         S_HALT:     if (wake_halt)   state_nx = S_WAKE_OSC;
         S_WAKE_OSC: if (settle_done) state_nx = S_WAKE_PLL;
         S_WAKE_PLL: state_nx = S_RUN;
         default:    state_nx = S_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= S_RUN;
         reset_seq_start <= 1'b0;
      end else begin
         state           <= state_nx;
         reset_seq_start <= (state == S_WAKE_PLL);
      end
   end

   // Unclocked path: an external pin in middle idle reopens the stopped domains at once.
   always_comb begin
      en = en_for(state);
      if (state == S_IDLE_M && ext_any) begin
         en.cpu = 1'b1;
         en.sys = 1'b1;
      end
   end

   assign clk_cpu_en = en.cpu;
   assign clk_sys_en = en.sys;
   assign clk_wd_en  = en.wd;
   assign pll_en     = en.pll;
   assign osc_en     = en.osc;
   assign lpm_status = (state == S_WAKE_OSC || state == S_WAKE_PLL) ? STAT_WAKING : 3'(state);

   // R5: light idle persists without a qualified source
   assert_light_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE_L && !wake_light) |=> (state == S_IDLE_L));
   // R6: middle idle persists without a qualified source
   assert_mid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE_M && !wake_mid) |=> (state == S_IDLE_M));
   // R8: only a reset request leaves halt
   assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HALT && !rst_req) |=> (state == S_HALT));
   // R9: the PLL is back before the system clock returns
   assert_pll_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_sys_en) |-> $past(pll_en));
   // R9: the PLL returns only after a stable oscillator was sampled
   assert_pll_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> $past(osc_ready));
   // R10: the start signal is a single-cycle pulse
   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seq_start |=> !reset_seq_start);
   // R11: a strobe with a pending wake source keeps the block running
   assert_strobe_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && idle_strobe && pending_sel) |=> (state == S_RUN));
endmodule

// File: tb/sim_lpm_sequencer.sv
`timescale 1ns/1ps
module sim_lpm_sequencer;
   localparam int NP = 3;
   localparam int NE = 2;
   localparam int NW = 2;
   localparam int SC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    lpm_mode = 2'b00;
   logic          idle_strobe = 1'b0;
   logic [NP-1:0] per_irq = '0;
   logic [NP-1:0] per_ie = '0;
   logic          glb_ie = 1'b0;
   logic [NE-1:0] ext_pin = '0;
   logic [NW-1:0] wkup_req = '0;
   logic          rst_req = 1'b0;
   logic          osc_ready = 1'b1;
   logic          clk_cpu_en, clk_sys_en, clk_wd_en, pll_en, osc_en;
   logic [NE-1:0] ext_irq_req;
   logic          reset_seq_start;
   logic [2:0]    lpm_status;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   lpm_sequencer #(.NPER(NP), .NEXT(NE), .NWK(NW), .SETTLE_CYC(SC)) u0 (
      .clk(clk), .rst_n(rst_n), .lpm_mode(lpm_mode), .idle_strobe(idle_strobe),
      .per_irq(per_irq), .per_ie(per_ie), .glb_ie(glb_ie), .ext_pin(ext_pin),
      .wkup_req(wkup_req), .rst_req(rst_req), .osc_ready(osc_ready),
      .clk_cpu_en(clk_cpu_en), .clk_sys_en(clk_sys_en), .clk_wd_en(clk_wd_en),
      .pll_en(pll_en), .osc_en(osc_en), .ext_irq_req(ext_irq_req),
      .reset_seq_start(reset_seq_start), .lpm_status(lpm_status)
   );

   wire [4:0] en_now = {clk_cpu_en, clk_sys_en, clk_wd_en, pll_en, osc_en};

   // stimulus kinds
   localparam logic [2:0] K_PER_OK = 3'd0, K_NOLOC = 3'd1, K_NOGLB = 3'd2,
                          K_EXT = 3'd3, K_WKUP = 3'd4, K_RSTQ = 3'd5;

   // {mode[13:12], kind[11:9], exits[8], status[7:5], enables[4:0]}
   localparam logic [13:0] VEC [11] = '{
      {2'b00, K_PER_OK, 1'b1, 3'd1, 5'b01111},
      {2'b00, K_NOLOC,  1'b0, 3'd1, 5'b01111},
      {2'b00, K_NOGLB,  1'b0, 3'd1, 5'b01111},
      {2'b00, K_EXT,    1'b1, 3'd1, 5'b01111},
      {2'b00, K_RSTQ,   1'b1, 3'd1, 5'b01111},
      {2'b01, K_WKUP,   1'b1, 3'd2, 5'b00111},
      {2'b01, K_PER_OK, 1'b0, 3'd2, 5'b00111},
      {2'b01, K_EXT,    1'b1, 3'd2, 5'b00111},
      {2'b01, K_RSTQ,   1'b1, 3'd2, 5'b00111},
      {2'b10, K_EXT,    1'b0, 3'd3, 5'b00000},
      {2'b11, K_WKUP,   1'b0, 3'd3, 5'b00000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic apply(input logic [2:0] kind);
      case (kind)
         K_PER_OK: begin per_irq = 3'b001; per_ie = 3'b001; glb_ie = 1'b1; end
         K_NOLOC:  begin per_irq = 3'b001; per_ie = 3'b110; glb_ie = 1'b1; end
         K_NOGLB:  begin per_irq = 3'b001; per_ie = 3'b001; glb_ie = 1'b0; end
         K_EXT:    ext_pin = 2'b01;
         K_WKUP:   wkup_req = 2'b10;
         default:  rst_req = 1'b1;
      endcase
   endtask

   task automatic clear_all();
      per_irq = '0; per_ie = '0; glb_ie = 1'b0;
      ext_pin = '0; wkup_req = '0; rst_req = 1'b0;
   endtask

   task automatic recover();
      @(negedge clk) rst_req = 1'b1;
      @(negedge clk) rst_req = 1'b0;
      for (int k = 0; k < 30; k++) begin
         if (lpm_status == 3'd0) break;
         @(negedge clk);
      end
   endtask

   function automatic string en_tag(input logic [2:0] st);
      if (st == 3'd1)      return "R2 light enables";
      else if (st == 3'd2) return "R3 middle enables";
      else                 return "R4 halt enables";
   endfunction

   function automatic string exit_tag(input logic [1:0] mode);
      if (mode == 2'b00)      return "R5 light exit";
      else if (mode == 2'b01) return "R6 middle exit";
      else                    return "R8 halt exit";
   endfunction

   initial begin
      cycles = 0;
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            summary();
         end
      end
   end

   initial begin
      // R13: state under reset
      #15;
      chk("R13 status", lpm_status, 3'd0);
      chk("R13 enables", en_now, 5'b11111);
      chk("R13 start", reset_seq_start, 1'b0);
      chk("R13 ext req", ext_irq_req, 2'b00);
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // table: enter each depth, apply one source, check exit or hold
      for (int i = 0; i < 11; i++) begin
         logic [13:0] v;
         v = VEC[i];
         @(negedge clk);
         lpm_mode = v[13:12];
         idle_strobe = 1'b1;
         @(negedge clk) idle_strobe = 1'b0;
         chk("R1 entry status", lpm_status, v[7:5]);
         chk(en_tag(v[7:5]), en_now, v[4:0]);
         apply(v[11:9]);
         #1;
         if (v[11:9] == K_EXT && v[7:5] == 3'd2)
            chk("R7 unclocked reopen", {clk_cpu_en, clk_sys_en}, 2'b11);
         if (v[7:5] == 3'd3)
            chk("R8 halt ignores source", en_now, 5'b00000);
         @(negedge clk) clear_all();
         chk(exit_tag(v[13:12]), lpm_status, v[8] ? 3'd0 : v[7:5]);
         if (v[8]) chk("R10 no start after idle exit", reset_seq_start, 1'b0);
         else      recover();
      end

      // R11: strobe with a pending source is dropped
      @(negedge clk);
      lpm_mode = 2'b00; per_irq = 3'b100; per_ie = 3'b100; glb_ie = 1'b1;
      idle_strobe = 1'b1;
      @(negedge clk) idle_strobe = 1'b0;
      chk("R11 light pending status", lpm_status, 3'd0);
      chk("R11 light pending enables", en_now, 5'b11111);
      clear_all();
      lpm_mode = 2'b01; wkup_req = 2'b01; idle_strobe = 1'b1;
      @(negedge clk) idle_strobe = 1'b0;
      chk("R11 middle pending status", lpm_status, 3'd0);
      chk("R11 middle pending enables", en_now, 5'b11111);
      clear_all();

      // R12: pin forwarded one edge later
      @(negedge clk) ext_pin = 2'b10;
      #1 chk("R12 before edge", ext_irq_req, 2'b00);
      @(negedge clk) chk("R12 after edge", ext_irq_req, 2'b10);
      ext_pin = 2'b00;
      @(negedge clk) chk("R12 release", ext_irq_req, 2'b00);

      // R9/R10: halt exit with steady oscillator
      lpm_mode = 2'b10; idle_strobe = 1'b1;
      @(negedge clk) idle_strobe = 1'b0;
      chk("R1 halt entry", lpm_status, 3'd3);
      osc_ready = 1'b1; rst_req = 1'b1;
      @(negedge clk) rst_req = 1'b0;
      chk("R8 waking status", lpm_status, 3'd4);
      chk("R8 oscillator only", en_now, 5'b00001);
      for (int k = 1; k < SC; k++) begin
         @(negedge clk);
         chk("R9 settling enables", en_now, 5'b00001);
      end
      @(negedge clk);
      chk("R9 pll stage enables", en_now, 5'b00111);
      chk("R9 pll stage status", lpm_status, 3'd4);
      chk("R10 no early start", reset_seq_start, 1'b0);
      @(negedge clk);
      chk("R9 run enables", en_now, 5'b11111);
      chk("R9 run status", lpm_status, 3'd0);
      chk("R10 start pulse", reset_seq_start, 1'b1);
      @(negedge clk);
      chk("R10 pulse ends", reset_seq_start, 1'b0);

      // R9: a ready dropout restarts the settle count
      lpm_mode = 2'b11; idle_strobe = 1'b1;
      @(negedge clk) idle_strobe = 1'b0;
      rst_req = 1'b1;
      @(negedge clk) rst_req = 1'b0;
      repeat (4) @(negedge clk);
      osc_ready = 1'b0;
      @(negedge clk) osc_ready = 1'b1;
      chk("R9 dropout holds", en_now, 5'b00001);
      for (int k = 1; k < SC; k++) begin
         @(negedge clk);
         chk("R9 recount enables", en_now, 5'b00001);
      end
      @(negedge clk);
      chk("R9 recount pll stage", en_now, 5'b00111);
      @(negedge clk);
      chk("R9 recount run", lpm_status, 3'd0);

      summary();
   end
endmodule